// File: doc/BRIEF.md
# Serial Channel Command and Mode Register Front End

This block is the per-channel control front end of a multi-channel asynchronous serial controller. A host reaches it through a byte-wide register bus. The high address bits pick the channel and the low three bits pick a register inside that channel. Each command byte can switch the receiver and transmitter on or off. In the same write it can also carry a four-bit command code that pulses a datapath reset, starts or stops a break, clears error flags, or moves the mode pointer.

A single mode address is shared by three configuration registers. A pointer steers each write to one of them and advances after every mode write. It goes from the FIFO/baud register to the character-format register, then to the stop-length register, and it stays on the last one.

A status byte at its own address combines four live datapath levels with four sticky error flags. Event pulses from the receive datapath set these flags, and command codes clear them. The outputs are levels, single-cycle pulses and decoded configuration fields for a transmit/receive datapath that sits outside this block.

Top module: `ser_ctl_regs`

## Requirements
- R1: Address bit 3 and above select the channel, and bits 2:0 select the register: 0 is mode, 1 is status, 2 is command. A write acts only on the addressed channel, and writes to offsets 3 to 7 change nothing.
- R2: In a command write, bit 0 turns the receiver on, bit 1 turns it off, bit 2 turns the transmitter on and bit 3 turns it off. When the on and off bits for the same direction are both set, off wins. When neither is set, the state holds.
- R3: Command code 2 (bits 7:4) raises `rx_reset` and code 3 raises `tx_reset`. Each pulse lasts exactly the one cycle after the write edge. No other code raises either pulse.
- R4: Command code 6 sets `break_on` and code 7 clears it.
- R5: Command code 1 points the mode pointer at the format register and code 0xB points it at the FIFO/baud register. After reset the pointer is at the format register.
- R6: Every mode write advances the pointer from FIFO/baud to format to stop-length. At stop-length the pointer stays, so further mode writes keep updating the stop-length register.
- R7: The format register drives `data_bits` from bits 1:0 (0 to 3 mean 5 to 8 bits) and `parity_mode` from bits 4:2 (0 even, 1 odd, 4 none). Both codes are passed through as written.
- R8: The stop-length register drives `stop_mode` from bits 3:0 (7 is one stop bit, 0xF is two). The FIFO/baud register drives `fifo_deep` from bit 3, `tx_half_lvl` from bit 4 and `baud_sel` from bits 2:0.
- R9: Reading offset 1 returns the following bits: 0 RX ready, 1 RX FIFO full, 2 TX ready, 3 TX empty, 4 overrun, 5 parity error, 6 framing error, 7 break received. Bits 3:0 are live inputs. Reading any other offset returns 0.
- R10: An overrun, parity, framing or break event sets the matching sticky status flag, and the flag stays set until it is cleared by command.
- R11: Command code 4 clears the overrun, parity and framing flags. Code 5 clears only the break flag. An event that arrives in the same cycle as its clear leaves the flag set.
- R12: Reset turns off both directions and the break, and zeroes all configuration fields and flags.
- R13: The enable bits and the command code of a single command byte both take effect from that one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Channel index above bit 3, register offset in bits 2:0 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register (combinational) |
| st_rx_ready | input | NCH | Live: receive data available |
| st_rx_full | input | NCH | Live: receive FIFO full |
| st_tx_ready | input | NCH | Live: transmit holding space free |
| st_tx_empty | input | NCH | Live: transmitter fully drained |
| ev_overrun | input | NCH | Overrun event pulse |
| ev_parity | input | NCH | Parity error event pulse |
| ev_framing | input | NCH | Framing error event pulse |
| ev_break | input | NCH | Break received event pulse |
| rx_enable | output | NCH | Receiver enable level |
| tx_enable | output | NCH | Transmitter enable level |
| rx_reset | output | NCH | One-cycle receiver reset pulse |
| tx_reset | output | NCH | One-cycle transmitter reset pulse |
| break_on | output | NCH | Transmit break level |
| data_bits | output | 2*NCH | Character length code |
| parity_mode | output | 3*NCH | Parity code |
| stop_mode | output | 4*NCH | Stop length code |
| fifo_deep | output | NCH | Deep FIFO enable |
| tx_half_lvl | output | NCH | Half-level transmit threshold select |
| baud_sel | output | 3*NCH | Baud table select |

## Verification
The bench builds the block with its default of two channels, so the address space is four bits wide. Random writes therefore land on both channels and on every one of the eight offsets, unused offsets included. Two channels make cross-channel isolation observable: a command to one channel must leave the other channel's levels, pointer and flags unchanged. With only two channels, event pulses and clears on both channels also coincide often, which exercises the rule that a set wins over a same-cycle clear.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;

    localparam logic [2:0] OFF_MODE   = 3'd0;
    localparam logic [2:0] OFF_STATUS = 3'd1;
    localparam logic [2:0] OFF_CMD    = 3'd2;

    localparam logic [3:0] CMD_PTR_FMT  = 4'h1;
    localparam logic [3:0] CMD_RX_RST   = 4'h2;
    localparam logic [3:0] CMD_TX_RST   = 4'h3;
    localparam logic [3:0] CMD_CLR_ERR  = 4'h4;
    localparam logic [3:0] CMD_CLR_BRK  = 4'h5;
    localparam logic [3:0] CMD_BRK_ON   = 4'h6;
    localparam logic [3:0] CMD_BRK_OFF  = 4'h7;
    localparam logic [3:0] CMD_PTR_FIFO = 4'hB;

    typedef enum logic [1:0] {
        PTR_FIFO = 2'd0,
        PTR_FMT  = 2'd1,
        PTR_STOP = 2'd2
    } mode_ptr_t;

    typedef struct packed {
        logic [2:0] baud;
        logic       half;
        logic       deep;
        logic [1:0] dbits;
        logic [2:0] par;
        logic [3:0] stop;
    } chan_cfg_t;

    function automatic mode_ptr_t next_ptr(mode_ptr_t p);
        case (p)
            PTR_FIFO: return PTR_FMT;
            default:  return PTR_STOP;
        endcase
    endfunction

endpackage

// File: rtl/ser_ctl_flags.sv
module ser_ctl_flags (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] set,      // {brk, frm, par, ovr}
    input  logic       clr_err,
    input  logic       clr_brk,
    output logic [3:0] q
);
    logic [3:0] clr_mask;
    assign clr_mask = {clr_brk, {3{clr_err}}};

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_mask) | set;
    end

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|set) |=> ((q & $past(set)) == $past(set)));
    // R11
    brk_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_brk && !set[3]) |=> !q[3]);
    // R11
    err_keep_brk_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_err && !clr_brk && q[3]) |=> q[3]);
endmodule

// File: rtl/ser_ctl_chan.sv
module ser_ctl_chan
    import ser_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [2:0] off,
    input  logic [7:0] wdata,
    input  logic [3:0] err_set,
    input  logic [3:0] live,     // {tx_empty, tx_ready, rx_full, rx_ready}
    output logic       rx_en,
    output logic       tx_en,
    output logic       rx_rst,
    output logic       tx_rst,
    output logic       brk_on,
    output chan_cfg_t  cfg,
    output logic [7:0] status
);
    logic       cmd_wr, mode_wr;
    logic [3:0] code;
    mode_ptr_t  ptr_q, ptr_d;
    logic [3:0] flags;

    assign cmd_wr  = wr && (off == OFF_CMD);
    assign mode_wr = wr && (off == OFF_MODE);
    assign code    = wdata[7:4];

    always_comb begin
        ptr_d = ptr_q;
        if (cmd_wr && code == CMD_PTR_FMT)       ptr_d = PTR_FMT;
        else if (cmd_wr && code == CMD_PTR_FIFO) ptr_d = PTR_FIFO;
        else if (mode_wr)                        ptr_d = next_ptr(ptr_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_en  <= 1'b0;
            tx_en  <= 1'b0;
            rx_rst <= 1'b0;
            tx_rst <= 1'b0;
            brk_on <= 1'b0;
            ptr_q  <= PTR_FMT;
            cfg    <= '0;
        end else begin
            ptr_q  <= ptr_d;
            rx_rst <= cmd_wr && code == CMD_RX_RST;
            tx_rst <= cmd_wr && code == CMD_TX_RST;
            if (cmd_wr) begin
                if (wdata[1])      rx_en <= 1'b0;
                else if (wdata[0]) rx_en <= 1'b1;
                if (wdata[3])      tx_en <= 1'b0;
                else if (wdata[2]) tx_en <= 1'b1;
                if (code == CMD_BRK_ON)  brk_on <= 1'b1;
                if (code == CMD_BRK_OFF) brk_on <= 1'b0;
            end
            if (mode_wr) begin
                case (ptr_q)
                    PTR_FIFO: begin
                        cfg.baud <= wdata[2:0];
                        cfg.deep <= wdata[3];
                        cfg.half <= wdata[4];
                    end
                    PTR_FMT: begin
                        cfg.dbits <= wdata[1:0];
                        cfg.par   <= wdata[4:2];
                    end
                    default: cfg.stop <= wdata[3:0];
                endcase
            end
        end
    end

    ser_ctl_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .set     (err_set),
        .clr_err (cmd_wr && code == CMD_CLR_ERR),
        .clr_brk (cmd_wr && code == CMD_CLR_BRK),
        .q       (flags)
    );

    assign status = {flags, live};

    // R2
    rx_off_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata[1]) |=> !rx_en);
    // R2
    tx_off_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata[3]) |=> !tx_en);
    // R3
    rx_rst_src_chk: assert property (@(posedge clk) disable iff (rst)
        rx_rst |-> $past(cmd_wr && code == CMD_RX_RST));
    // R3
    rst_pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_rst, tx_rst}));
    // R5
    ptr_fifo_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && code == CMD_PTR_FIFO) |=> ptr_q == PTR_FIFO);
    // R6
    ptr_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr_q == PTR_STOP && mode_wr) |=> ptr_q == PTR_STOP);
endmodule

// File: rtl/ser_ctl_regs.sv
module ser_ctl_regs
    import ser_ctl_pkg::*;
#(
    parameter  int NCH    = 2,
    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int ADDR_W = 3 + CH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [NCH-1:0]    st_rx_ready,
    input  logic [NCH-1:0]    st_rx_full,
    input  logic [NCH-1:0]    st_tx_ready,
    input  logic [NCH-1:0]    st_tx_empty,
    input  logic [NCH-1:0]    ev_overrun,
    input  logic [NCH-1:0]    ev_parity,
    input  logic [NCH-1:0]    ev_framing,
    input  logic [NCH-1:0]    ev_break,
    output logic [NCH-1:0]    rx_enable,
    output logic [NCH-1:0]    tx_enable,
    output logic [NCH-1:0]    rx_reset,
    output logic [NCH-1:0]    tx_reset,
    output logic [NCH-1:0]    break_on,
    output logic [2*NCH-1:0]  data_bits,
    output logic [3*NCH-1:0]  parity_mode,
    output logic [4*NCH-1:0]  stop_mode,
    output logic [NCH-1:0]    fifo_deep,
    output logic [NCH-1:0]    tx_half_lvl,
    output logic [3*NCH-1:0]  baud_sel
);
    logic [7:0]      stat [NCH];
    logic [CH_W-1:0] ch_sel;
    logic [2:0]      off;

    assign ch_sel = addr[ADDR_W-1:3];
    assign off    = addr[2:0];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        chan_cfg_t cfg;
        ser_ctl_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .wr      (wr_en && ch_sel == CH_W'(i)),
            .off     (off),
            .wdata   (wdata),
            .err_set ({ev_break[i], ev_framing[i], ev_parity[i], ev_overrun[i]}),
            .live    ({st_tx_empty[i], st_tx_ready[i], st_rx_full[i], st_rx_ready[i]}),
            .rx_en   (rx_enable[i]),
            .tx_en   (tx_enable[i]),
            .rx_rst  (rx_reset[i]),
            .tx_rst  (tx_reset[i]),
            .brk_on  (break_on[i]),
            .cfg     (cfg),
            .status  (stat[i])
        );
        assign data_bits[2*i +: 2]   = cfg.dbits;
        assign parity_mode[3*i +: 3] = cfg.par;
        assign stop_mode[4*i +: 4]   = cfg.stop;
        assign fifo_deep[i]          = cfg.deep;
        assign tx_half_lvl[i]        = cfg.half;
        assign baud_sel[3*i +: 3]    = cfg.baud;
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NCH; i++)
            if (ch_sel == CH_W'(i) && off == OFF_STATUS) rdata = stat[i];
    end

    // R1
    one_chan_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rx_reset | tx_reset));
endmodule

// File: tb/ser_ctl_regs_test.sv
module ser_ctl_regs_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] st_rx_ready = '0, st_rx_full = '0, st_tx_ready = '0, st_tx_empty = '0;
    logic [1:0] ev_overrun = '0, ev_parity = '0, ev_framing = '0, ev_break = '0;
    logic [1:0] rx_enable, tx_enable, rx_reset, tx_reset, break_on, fifo_deep, tx_half_lvl;
    logic [3:0] data_bits;
    logic [5:0] parity_mode, baud_sel;
    logic [7:0] stop_mode;

    always #2.5 clk = ~clk;

    ser_ctl_regs uut (.*);

    int n_chk = 0, n_err = 0;
    logic       e_rx[2], e_tx[2], e_brk[2], e_rxr[2], e_txr[2], e_deep[2], e_half[2];
    logic [1:0] e_db[2];
    logic [2:0] e_par[2], e_baud[2];
    logic [3:0] e_stop[2], e_flag[2];
    int         e_ptr[2];

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void model(logic w, logic [3:0] a, logic [7:0] d, logic [7:0] ev);
        for (int c = 0; c < 2; c++) begin
            logic sel = w && (a[3] == c[0]);
            logic [3:0] code = d[7:4];
            logic [3:0] clr;
            e_rxr[c] = sel && a[2:0] == 3'd2 && code == 4'h2;
            e_txr[c] = sel && a[2:0] == 3'd2 && code == 4'h3;
            clr = '0;
            if (sel && a[2:0] == 3'd2) begin
                if (d[1]) e_rx[c] = 1'b0; else if (d[0]) e_rx[c] = 1'b1;
                if (d[3]) e_tx[c] = 1'b0; else if (d[2]) e_tx[c] = 1'b1;
                if (code == 4'h6) e_brk[c] = 1'b1;
                if (code == 4'h7) e_brk[c] = 1'b0;
                if (code == 4'h1) e_ptr[c] = 1;
                if (code == 4'hB) e_ptr[c] = 0;
                if (code == 4'h4) clr = 4'b0111;
                if (code == 4'h5) clr = 4'b1000;
            end
            if (sel && a[2:0] == 3'd0) begin
                case (e_ptr[c])
                    0: begin e_baud[c] = d[2:0]; e_deep[c] = d[3]; e_half[c] = d[4]; e_ptr[c] = 1; end
                    1: begin e_db[c] = d[1:0]; e_par[c] = d[4:2]; e_ptr[c] = 2; end
                    default: e_stop[c] = d[3:0];
                endcase
            end
            e_flag[c] = (e_flag[c] & ~clr) | ev[4*c +: 4];
        end
    endfunction

    task automatic compare_all(string tag);
        for (int c = 0; c < 2; c++) begin
            chk("R2", {tag, " rx_enable"}, rx_enable[c], e_rx[c]);
            chk("R2", {tag, " tx_enable"}, tx_enable[c], e_tx[c]);
            chk("R3", {tag, " rx_reset"}, rx_reset[c], e_rxr[c]);
            chk("R3", {tag, " tx_reset"}, tx_reset[c], e_txr[c]);
            chk("R4", {tag, " break_on"}, break_on[c], e_brk[c]);
            chk("R7", {tag, " data_bits"}, data_bits[2*c +: 2], e_db[c]);
            chk("R7", {tag, " parity_mode"}, parity_mode[3*c +: 3], e_par[c]);
            chk("R8", {tag, " stop_mode"}, stop_mode[4*c +: 4], e_stop[c]);
            chk("R8", {tag, " fifo_deep"}, fifo_deep[c], e_deep[c]);
            chk("R8", {tag, " tx_half_lvl"}, tx_half_lvl[c], e_half[c]);
            chk("R8", {tag, " baud_sel"}, baud_sel[3*c +: 3], e_baud[c]);
        end
    endtask

    // ev bits per channel: {brk, frm, par, ovr}
    task automatic op(logic w, logic [3:0] a, logic [7:0] d, logic [7:0] ev, string tag);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d;
        ev_overrun = {ev[4], ev[0]}; ev_parity = {ev[5], ev[1]};
        ev_framing = {ev[6], ev[2]}; ev_break  = {ev[7], ev[3]};
        @(posedge clk);
        model(w, a, d, ev);
        @(negedge clk);
        wr_en = 1'b0; ev_overrun = '0; ev_parity = '0; ev_framing = '0; ev_break = '0;
        compare_all(tag);
    endtask

    // R9 R10 R11: status read at offset 1, zero elsewhere
    task automatic rd_chk(int c, string tag);
        logic [3:0] lv;
        @(negedge clk);
        lv = 4'($urandom);
        {st_tx_empty[c], st_tx_ready[c], st_rx_full[c], st_rx_ready[c]} = lv;
        addr = {c[0], 3'd1};
        #1 chk("R9", {tag, " status"}, rdata, {e_flag[c], lv});
        addr = {c[0], 3'($urandom_range(2, 7))};
        #1 chk("R9", {tag, " non-status read"}, rdata, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int c = 0; c < 2; c++) begin
            e_rx[c] = 0; e_tx[c] = 0; e_brk[c] = 0; e_rxr[c] = 0; e_txr[c] = 0;
            e_deep[c] = 0; e_half[c] = 0; e_db[c] = 0; e_par[c] = 0; e_baud[c] = 0;
            e_stop[c] = 0; e_flag[c] = 0; e_ptr[c] = 1;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R12 reset state
        @(negedge clk);
        chk("R12", "rx_enable", rx_enable, 2'b00);
        chk("R12", "break_on", break_on, 2'b00);
        chk("R12", "config", {data_bits, parity_mode, stop_mode, baud_sel}, '0);
        rd_chk(0, "R12 reset flags");
        // R5 reset pointer at format register, then R6 advance to stop
        op(1, 4'h0, 8'h0F, 0, "R5 first mode write");
        chk("R5", "fmt after reset", {data_bits[1:0], parity_mode[2:0]}, {2'b11, 3'b011});
        op(1, 4'h0, 8'h07, 0, "R6 stop write");
        op(1, 4'h0, 8'h0F, 0, "R6 stop stays");
        chk("R6", "stop repeat", stop_mode[3:0], 4'hF);
        // R5 R8 pointer to fifo/baud
        op(1, 4'h2, 8'hB0, 0, "R5 ptr fifo");
        op(1, 4'h0, 8'h1D, 0, "R8 fifo/baud");
        chk("R8", "fifo/baud", {tx_half_lvl[0], fifo_deep[0], baud_sel[2:0]}, 5'b11101);
        // R2 off wins
        op(1, 4'h2, 8'h05, 0, "R2 enable both");
        op(1, 4'h2, 8'h0F, 0, "R2 off wins");
        chk("R2", "both off", {rx_enable[0], tx_enable[0]}, 2'b00);
        // R13 enable plus break in one byte, R1 on channel 1 only
        op(1, 4'hA, 8'h65, 0, "R13 combined");
        chk("R13", "combined", {rx_enable[1], tx_enable[1], break_on[1]}, 3'b111);
        chk("R1", "other channel untouched", {rx_enable[0], break_on[0]}, 2'b00);
        op(1, 4'hB, 8'hFF, 0, "R1 unused offset");
        // R3 pulses and their drop
        op(1, 4'h2, 8'h20, 0, "R3 rx reset");
        op(0, 4'h0, 8'h00, 0, "R3 idle after");
        op(1, 4'hA, 8'h30, 0, "R3 tx reset");
        // R10 R11 flags
        op(0, 4'h0, 8'h00, 8'hFF, "R10 events");
        rd_chk(0, "R10 set"); rd_chk(1, "R10 set");
        op(1, 4'h2, 8'h40, 0, "R11 clear err");
        rd_chk(0, "R11 brk kept");
        op(1, 4'h2, 8'h50, 8'h08, "R11 set wins");
        rd_chk(0, "R11 set wins");
        op(1, 4'h2, 8'h50, 0, "R11 clear brk");
        rd_chk(0, "R11 brk cleared");
        // random mix
        for (int k = 0; k < 600; k++) begin
            logic [7:0] d = 8'($urandom);
            logic [3:0] a = 4'($urandom);
            if ($urandom_range(0, 1) == 0) a[2:1] = 2'b00 | {1'b0, a[1]} << 1;
            op(1'($urandom), a, d, 8'($urandom) & 8'($urandom), "random");
            if (k % 8 == 0) rd_chk(k % 16 == 0 ? 0 : 1, "random");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule